// File: doc/BRIEF.md
# Dual-Mode Serial Clock Divider

This block derives the serial clock of a serial-peripheral master from a faster module clock. Two divide schemes are available and a select bit chooses between them at run time. In linear mode the module clock is divided by an even number, 2*(N+1), with N an 8-bit value. In exponential mode it is divided by 2^(M+1), with M a 4-bit value. Since a full serial period is never shorter than two module cycles, the module clock always runs at least twice as fast as the serial clock.

The transfer engine holds `run` high for the length of a transfer. While `run` is low the block copies the divider settings and the clock polarity into shadow registers, holds the serial clock at its idle level and keeps both edge strobes low. While `run` is high the shadow copy is frozen and the serial clock toggles once per half-period. Each toggle comes with a one-cycle strobe that says whether the edge was leading (moving away from the idle level) or trailing (moving back to it). A phase-aware shifter uses these strobes to sample and launch data.

Top module: `spi_sclk_div`

## Requirements
- R1: With `lin_sel`=1, each half-period of `sclk` lasts N+1 module cycles, with N = `lin_div`. The first toggle appears N+1 cycles after the first rising clock edge that samples `run` high.
- R2: With `lin_sel`=0, each half-period lasts 2^M module cycles, with M = `exp_div`, so the full period is 2^(M+1). Timing from `run` is measured the same way as in R1.
- R3: `lin_sel`=1 selects the linear field and `lin_sel`=0 selects the exponential field. The field that is not selected has no effect.
- R4: N=0 in linear mode gives division by 2: `sclk` toggles on every cycle.
- R5: The settings (`lin_sel`, `lin_div`, `exp_div`, `cpol`) are captured only on clock edges that sample `run` low. Changes made while `run` is high take effect only at the next transfer.
- R6: On the cycle after a clock edge that samples `run` low, `sclk` equals the `cpol` value sampled on that edge, and `lead_pls` and `trail_pls` are both 0.
- R7: Every toggle of `sclk` while running comes with exactly one strobe in the same cycle. The strobe is `lead_pls` when `sclk` leaves the captured idle level and `trail_pls` when it returns to that level. No strobe appears without a toggle.
- R8: After synchronous reset, `sclk`, `lead_pls` and `trail_pls` are 0.
- R9: With `cpol`=1 the idle level is high, so the leading edge is a falling edge of `sclk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | High for the duration of a transfer |
| cpol | input | 1 | Idle level of the serial clock |
| lin_sel | input | 1 | 1: linear divide, 0: power-of-two divide |
| lin_div | input | 8 | Linear field N |
| exp_div | input | 4 | Exponential field M |
| sclk | output | 1 | Serial clock, registered |
| lead_pls | output | 1 | One-cycle strobe on a leading edge |
| trail_pls | output | 1 | One-cycle strobe on a trailing edge |

## Verification
The assertions assume that the divider fields and `cpol` may change at any time. They only require the shadow copy to stay frozen while `run` is high, and they tie the strobes to the captured polarity and not to the live input. The stimulus changes settings in the middle of a transfer on purpose. It also stops transfers partway through a half-period and leaves at least one idle cycle between transfers, so that the new settings are captured before `run` rises again.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;
  localparam int LIN_W = 8;
  localparam int EXP_W = 4;

  typedef struct packed {
    logic             lin_sel;
    logic [LIN_W-1:0] n;
    logic [EXP_W-1:0] m;
    logic             cpol;
  } div_cfg_t;
endpackage

// File: rtl/div_cfg_shadow.sv
module div_cfg_shadow
  import spi_div_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     run,
  input  div_cfg_t cfg_in,
  output div_cfg_t cfg_q
);
  always_ff @(posedge clk) begin
    if (rst)       cfg_q <= '0;
    else if (!run) cfg_q <= cfg_in;
  end

  // R5
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    run |=> $stable(cfg_q));
endmodule

// File: rtl/div_tick_gen.sv
module div_tick_gen
  import spi_div_pkg::*;
#(
  parameter int LIN_WIDTH = LIN_W,
  parameter int EXP_WIDTH = EXP_W
)(
  input  logic     clk,
  input  logic     rst,
  input  logic     run,
  input  div_cfg_t cfg,
  output logic     tick
);
  localparam int EXP_SPAN = 1 << EXP_WIDTH;
  localparam int CNT_W    = (LIN_WIDTH > EXP_SPAN) ? LIN_WIDTH : EXP_SPAN;

  logic [CNT_W-1:0] cnt, cnt_inc;
  logic             lin_hit, exp_hit;

  assign cnt_inc = cnt + 1'b1;
  assign lin_hit = (cnt[LIN_WIDTH-1:0] == cfg.n);
  // power-of-two mode: a half-period ends when the selected bit flips
  assign exp_hit = cnt[cfg.m] ^ cnt_inc[cfg.m];
  assign tick    = run && (cfg.lin_sel ? lin_hit : exp_hit);

  always_ff @(posedge clk) begin
    if (rst || !run)                 cnt <= '0;
    else if (cfg.lin_sel && lin_hit) cnt <= '0;
    else                             cnt <= cnt_inc;
  end

  // R1
  lin_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (run && cfg.lin_sel) |-> (cnt[LIN_WIDTH-1:0] <= cfg.n));
endmodule

// File: rtl/sclk_edge_gen.sv
module sclk_edge_gen (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  input  logic cpol_in,
  input  logic cpol_cfg,
  output logic sclk,
  output logic lead_pls,
  output logic trail_pls
);
  logic at_idle;
  assign at_idle = (sclk == cpol_cfg);

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk      <= 1'b0;
      lead_pls  <= 1'b0;
      trail_pls <= 1'b0;
    end else if (!run) begin
      sclk      <= cpol_in;
      lead_pls  <= 1'b0;
      trail_pls <= 1'b0;
    end else begin
      lead_pls  <= tick && at_idle;
      trail_pls <= tick && !at_idle;
      if (tick) sclk <= ~sclk;
    end
  end

  // R7
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lead_pls, trail_pls}));
  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!lead_pls && !trail_pls));
endmodule

// File: rtl/spi_sclk_div.sv
module spi_sclk_div
  import spi_div_pkg::*;
#(
  parameter int LIN_WIDTH = LIN_W,
  parameter int EXP_WIDTH = EXP_W
)(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic                 cpol,
  input  logic                 lin_sel,
  input  logic [LIN_WIDTH-1:0] lin_div,
  input  logic [EXP_WIDTH-1:0] exp_div,
  output logic                 sclk,
  output logic                 lead_pls,
  output logic                 trail_pls
);
  div_cfg_t cfg_in, cfg_q;
  logic     tick;

  assign cfg_in = '{lin_sel: lin_sel, n: lin_div, m: exp_div, cpol: cpol};

  div_cfg_shadow u_shadow (
    .clk(clk), .rst(rst), .run(run), .cfg_in(cfg_in), .cfg_q(cfg_q)
  );

  div_tick_gen #(.LIN_WIDTH(LIN_WIDTH), .EXP_WIDTH(EXP_WIDTH)) u_tick (
    .clk(clk), .rst(rst), .run(run), .cfg(cfg_q), .tick(tick)
  );

  sclk_edge_gen u_edge (
    .clk(clk), .rst(rst), .run(run), .tick(tick),
    .cpol_in(cpol), .cpol_cfg(cfg_q.cpol),
    .sclk(sclk), .lead_pls(lead_pls), .trail_pls(trail_pls)
  );

  // R7
  strobe_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (lead_pls || trail_pls) |-> (sclk != $past(sclk)));
  // R9
  lead_level_chk: assert property (@(posedge clk) disable iff (rst)
    lead_pls |-> (sclk != cfg_q.cpol));
  // R7
  trail_level_chk: assert property (@(posedge clk) disable iff (rst)
    trail_pls |-> (sclk == cfg_q.cpol));
endmodule

// File: tb/spi_sclk_div_tb.sv
module spi_sclk_div_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run = 1'b0;
  logic       cpol = 1'b0;
  logic       lin_sel = 1'b1;
  logic [7:0] lin_div = 8'd0;
  logic [3:0] exp_div = 4'd0;
  logic       sclk, lead_pls, trail_pls;

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_req = "R8";
  bit    done    = 1'b0;

  always #4 clk = ~clk;

  spi_sclk_div u_dut (
    .clk(clk), .rst(rst), .run(run), .cpol(cpol), .lin_sel(lin_sel),
    .lin_div(lin_div), .exp_div(exp_div),
    .sclk(sclk), .lead_pls(lead_pls), .trail_pls(trail_pls)
  );

  // behavioural reference
  bit m_sclk, m_lead, m_trail;
  bit s_sel, s_cpol;
  int s_n, s_m, k;

  always @(posedge clk) begin
    if (rst) begin
      m_sclk = 0; m_lead = 0; m_trail = 0; k = 0;
      s_sel = 0; s_cpol = 0; s_n = 0; s_m = 0;
    end else if (!run) begin
      s_sel = lin_sel; s_cpol = cpol; s_n = lin_div; s_m = exp_div;
      m_sclk = cpol; m_lead = 0; m_trail = 0; k = 0;
    end else begin
      int half;
      half = s_sel ? s_n + 1 : (1 << s_m);
      m_lead = 0; m_trail = 0; k++;
      if (k == half) begin
        k = 0;
        if (m_sclk == s_cpol) m_lead = 1; else m_trail = 1;
        m_sclk = ~m_sclk;
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(cur_req, "sclk", sclk, m_sclk);
      check(cur_req, "lead", lead_pls, m_lead);
      check(cur_req, "trail", trail_pls, m_trail);
    end
  end

  int cnt_lead, cnt_trail;
  task automatic run_for(int n);
    cnt_lead = 0; cnt_trail = 0;
    run = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cnt_lead  += lead_pls;
      cnt_trail += trail_pls;
    end
  endtask

  task automatic idle_for(int n);
    run = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R8";
    check("R8", "reset sclk", sclk, 0);
    check("R8", "reset lead", lead_pls, 0);
    rst = 1'b0;

    // R6 / R9: idle level follows cpol
    cur_req = "R6"; cpol = 1'b1;
    idle_for(3);
    check("R9", "idle high", sclk, 1);

    // R1, R3, R7: linear N=3, cpol=0
    cur_req = "R1"; cpol = 1'b0; lin_sel = 1'b1; lin_div = 8'd3; exp_div = 4'd1;
    idle_for(2);
    run_for(40);
    check("R1", "lin leads", cnt_lead, 5);
    check("R7", "lin trails", cnt_trail, 5);

    // R4: N=0
    cur_req = "R4"; lin_div = 8'd0;
    idle_for(2);
    run_for(10);
    check("R4", "div2 leads", cnt_lead, 5);
    check("R4", "div2 trails", cnt_trail, 5);

    // R2, R9: exponential M=2, cpol=1; the linear field is ignored (R3)
    cur_req = "R2"; lin_sel = 1'b0; exp_div = 4'd2; cpol = 1'b1; lin_div = 8'd7;
    idle_for(2);
    run_for(16);
    check("R2", "exp leads", cnt_lead, 2);
    check("R3", "exp trails", cnt_trail, 2);

    // R2: M=0
    cur_req = "R2"; exp_div = 4'd0; cpol = 1'b0;
    idle_for(2);
    run_for(6);
    check("R2", "exp0 edges", cnt_lead + cnt_trail, 6);

    // R5: change while running is ignored until next transfer
    cur_req = "R5"; lin_sel = 1'b1; lin_div = 8'd3;
    idle_for(2);
    run_for(8);
    lin_div = 8'd0; lin_sel = 1'b0; exp_div = 4'd3; cpol = 1'b1;
    run_for(8);
    check("R5", "frozen edges", cnt_lead + cnt_trail, 2);
    check("R5", "frozen sclk low", sclk, 0);
    idle_for(1);
    check("R6", "stop level", sclk, 1);
    cpol = 1'b0; lin_sel = 1'b1;
    idle_for(1);
    run_for(6);
    check("R5", "new cfg edges", cnt_lead + cnt_trail, 6);

    // R6: stop mid half-period
    cur_req = "R6"; lin_div = 8'd5;
    idle_for(2);
    run_for(3);
    idle_for(1);
    check("R6", "mid stop lead", lead_pls, 0);
    check("R6", "mid stop sclk", sclk, 0);
    idle_for(3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule